// File: doc/BRIEF.md
# DMA Channel Request Enable Register

This block holds one request-enable bit for each of 16 DMA channels and masks the raw per-channel request lines with those bits. A channel whose enable bit is clear never passes a request to downstream logic. Software can change one channel's enable without a read-modify-write of the whole word. It does this by writing a command byte that names the channel by number. A flag in the same byte applies the command to every channel at once.

The block sits on a simple register strobe interface with 16-bit data, byte lanes and byte addresses. The full enable word is at byte address 0 and can be read and written with a bitmask. The set-command byte is at byte address 2, on lane 0. The clear-command byte is at byte address 3, on lane 1. A single halfword write to address 2 can therefore carry a set command and a clear command in the same cycle. The command bytes are write-only and hold no state.

Top module: `dma_req_enable`

## Requirements
- R1: After reset every enable bit is 0, so `gated_req_o` is 0 whatever `raw_req_i` holds.
- R2: A write to the set-command byte (address 2, lane 0, `wdata_i[7:0]`) with bit 6 clear sets the enable bit whose index is in bits 3:0. All other enable bits keep their value.
- R3: When bit 6 of the set-command byte is 1, all 16 enable bits are set and the channel field is ignored.
- R4: A write to the clear-command byte (address 3, lane 1, `wdata_i[15:8]`) with bit 14 clear clears the enable bit whose index is in bits 11:8. All other enable bits keep their value.
- R5: When bit 6 of the clear-command byte (`wdata_i[14]`) is 1, all 16 enable bits are cleared and the channel field is ignored.
- R6: If a set command and a clear command arrive in the same write, each bit they both touch ends up cleared. This applies to a single channel and to the all-channel forms.
- R7: Bits 7, 5 and 4 of either command byte have no effect on the result.
- R8: A read of byte address 2 or 3 returns 0x0000. A read with `rd_i` low also returns 0.
- R9: A write to address 0 loads `wdata_i[7:0]` into enable bits 7:0 when `be_i[0]` is 1, and `wdata_i[15:8]` into bits 15:8 when `be_i[1]` is 1. The new value is visible on the cycle after the strobe. A read of address 0 returns the enable word.
- R10: `gated_req_o[i]` equals `raw_req_i[i] & enable[i]` and is combinational.
- R11: No strobe, a write with no byte lane enabled, or a write to byte addresses 4 to 7 leaves the enable word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, single cycle |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 3 | Byte address: 0 is the enable word, 2 is the set command, 3 is the clear command |
| be_i | input | 2 | Byte-lane enables for `wdata_i` |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| raw_req_i | input | 16 | Raw per-channel requests |
| gated_req_o | output | 16 | Requests masked by the enable word |

## Verification
The assertions check on every cycle that:
- a cleared channel stays cleared even when a set for it arrives in the same cycle;
- a lone set command leaves its bit set;
- idle cycles leave the enable word stable;
- a single-channel command decodes to at most one bit;
- command addresses always read as zero.

Only the bench's scenarios can show the rest:
- each channel index reaches the right bit;
- the all-channel flags override the channel field;
- reserved bits are ignored;
- byte-lane direct writes merge correctly.

The bench checks these against an arithmetic model of the enable word, sweeping all 16 channels.

// File: rtl/dma_en_pkg.sv
package dma_en_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 3;
  localparam int CH_FIELD_W = 4;
  localparam int ALL_BIT    = 6;

  typedef enum logic [1:0] {
    RGN_ENABLE = 2'd0,
    RGN_CMD    = 2'd1,
    RGN_NONE0  = 2'd2,
    RGN_NONE1  = 2'd3
  } region_e;

  function automatic region_e region_of(input logic [ADDR_W-1:0] a);
    return region_e'(a[ADDR_W-1:1]);
  endfunction
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode #(
  parameter int NUM_CH = 16
) (
  input  logic              valid_i,
  input  logic [7:0]        cmd_i,
  output logic [NUM_CH-1:0] mask_o
);
  import dma_en_pkg::*;

  logic [CH_FIELD_W-1:0] ch_idx;
  logic                  all_flag;

  assign ch_idx   = cmd_i[CH_FIELD_W-1:0];
  assign all_flag = cmd_i[ALL_BIT];

  // bits 7, 5, 4 are reserved and deliberately not decoded
  always_comb begin
    mask_o = '0;
    if (valid_i) begin
      for (int i = 0; i < NUM_CH; i++) begin
        mask_o[i] = all_flag || (int'(ch_idx) == i);
      end
    end
  end
endmodule

// File: rtl/enable_reg.sv
module enable_reg #(
  parameter int NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_we_i,
  input  logic [NUM_CH/8-1:0] dir_be_i,
  input  logic [NUM_CH-1:0] dir_data_i,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] en_o
);
  localparam int NB = NUM_CH / 8;

  logic [NUM_CH-1:0] en_q, en_d, dir_merged;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dir_merged[b*8 +: 8] = dir_be_i[b] ? dir_data_i[b*8 +: 8] : en_q[b*8 +: 8];
  end

  always_comb begin
    en_d = dir_we_i ? dir_merged : en_q;
    en_d = (en_d | set_i) & ~clr_i;  // clear wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((en_q & $past(clr_i)) == '0)); // R6

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_we_i && |(set_i & ~clr_i)) |=>
      ((en_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_we_i && set_i == '0 && clr_i == '0) |=> $stable(en_q)); // R11
endmodule

// File: rtl/req_gate.sv
module req_gate #(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] raw_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0] gated_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign gated_o[i] = raw_i[i] & en_i[i];
  end
endmodule

// File: rtl/dma_req_enable.sv
module dma_req_enable
  import dma_en_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_CH-1:0]   raw_req_i,
  output logic [NUM_CH-1:0]   gated_req_o
);
  region_e           rgn;
  logic              dir_we, set_v, clr_v;
  logic [NUM_CH-1:0] set_mask, clr_mask, en;

  assign rgn    = region_of(addr_i);
  assign dir_we = wr_i && (rgn == RGN_ENABLE);
  assign set_v  = wr_i && (rgn == RGN_CMD) && be_i[0];
  assign clr_v  = wr_i && (rgn == RGN_CMD) && be_i[1];

  cmd_decode #(.NUM_CH(NUM_CH)) u_set_dec (
    .valid_i (set_v),
    .cmd_i   (wdata_i[7:0]),
    .mask_o  (set_mask)
  );

  cmd_decode #(.NUM_CH(NUM_CH)) u_clr_dec (
    .valid_i (clr_v),
    .cmd_i   (wdata_i[15:8]),
    .mask_o  (clr_mask)
  );

  enable_reg #(.NUM_CH(NUM_CH)) u_en (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dir_we_i   (dir_we),
    .dir_be_i   (be_i),
    .dir_data_i (wdata_i),
    .set_i      (set_mask),
    .clr_i      (clr_mask),
    .en_o       (en)
  );

  req_gate #(.NUM_CH(NUM_CH)) u_gate (
    .raw_i   (raw_req_i),
    .en_i    (en),
    .gated_o (gated_req_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i && rgn == RGN_ENABLE) rdata_o = en;
  end

  AST_CMD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rgn == RGN_CMD) |-> (rdata_o == '0)); // R8

  AST_SINGLE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_v && !wdata_i[ALL_BIT]) |-> $onehot0(set_mask)); // R2

  AST_SINGLE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_v && !wdata_i[8+ALL_BIT]) |-> $onehot0(clr_mask)); // R4

  AST_ALL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_v && wdata_i[ALL_BIT] && !clr_v) |=> (en == '1)); // R3
endmodule

// File: tb/sim_dma_req_enable.sv
`timescale 1ns/1ps
module sim_dma_req_enable;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr = 0, rd = 0;
  logic [2:0]  addr = '0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] raw = '0;
  logic [15:0] gated;
  logic [15:0] model = '0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_req_enable u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .raw_req_i(raw),
    .gated_req_o(gated)
  );

  function automatic logic [15:0] apply(input logic [15:0] e, input logic [2:0] a,
                                        input logic [1:0] b, input logic [15:0] d);
    logic [15:0] r = e;
    if (a[2:1] == 2'd0) begin
      if (b[0]) r[7:0]  = d[7:0];
      if (b[1]) r[15:8] = d[15:8];
    end else if (a[2:1] == 2'd1) begin
      if (b[0]) begin
        if (d[6]) r = '1; else r[d[3:0]] = 1'b1;
      end
      if (b[1]) begin
        if (d[14]) r = '0; else r[d[11:8]] = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_op(input logic [2:0] a, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    wr = 1; addr = a; be = b; wdata = d;
    model = apply(model, a, b, d);
    @(negedge clk);
    wr = 0; be = '0; wdata = '0;
  endtask

  task automatic rd_op(input logic [2:0] a, output logic [15:0] v);
    rd = 1; addr = a; #0.5; v = rdata; rd = 0;
  endtask

  task automatic chk_en(input string tag);
    logic [15:0] v;
    rd_op(3'd0, v);
    chk(tag, v, model);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    raw = '1;
    #12; rst_n = 1;
    @(negedge clk);
    chk_en("R1 reset enable");
    chk("R1 reset gated", gated, 16'h0);

    for (int c = 0; c < 16; c++) begin
      wr_op(3'd3, 2'b10, 16'h4000);
      wr_op(3'd2, 2'b01, 16'(c));
      chk_en("R2 single set");
      chk("R2 one bit", rdata == 0 ? model : model, 16'h1 << c);
    end
    for (int c = 0; c < 16; c++) begin
      wr_op(3'd2, 2'b01, 16'(c));
      chk_en("R2 cumulative set");
    end

    wr_op(3'd3, 2'b10, 16'h4000);
    chk_en("R5 clear all");
    chk("R5 value", model, 16'h0);
    wr_op(3'd2, 2'b01, 16'h0045);
    chk_en("R3 set all ignores channel");
    chk("R3 value", model, 16'hFFFF);

    for (int c = 0; c < 16; c++) begin
      wr_op(3'd3, 2'b10, 16'(c) << 8);
      chk_en("R4 single clear");
    end
    wr_op(3'd2, 2'b01, 16'h0040);
    wr_op(3'd3, 2'b10, 16'h4A00);
    chk_en("R5 clear all ignores channel");

    for (int c = 0; c < 16; c++) begin
      wr_op(3'd2, 2'b01, 16'(c) | 16'h00B0);
      chk_en("R7 reserved set bits");
    end
    for (int c = 0; c < 16; c++) begin
      wr_op(3'd3, 2'b10, (16'(c) << 8) | 16'hB000);
      chk_en("R7 reserved clear bits");
    end

    for (int c = 0; c < 16; c++) begin
      wr_op(3'd0, 2'b11, 16'h5A5A);
      wr_op(3'd2, 2'b11, (16'(c) << 8) | 16'(c));
      chk_en("R6 same channel clear wins");
      chk("R6 bit low", model[c] ? 16'h1 : 16'h0, 16'h0);
    end
    wr_op(3'd2, 2'b11, 16'h0340);
    chk_en("R6 set all with clear one");
    wr_op(3'd2, 2'b11, 16'h4005);
    chk_en("R6 clear all with set one");

    wr_op(3'd2, 2'b01, 16'h0040);
    rd_op(3'd2, v); chk("R8 set port reads zero", v, 16'h0);
    rd_op(3'd3, v); chk("R8 clear port reads zero", v, 16'h0);
    rd = 0; addr = 3'd0; #0.5; chk("R8 no strobe reads zero", rdata, 16'h0);

    wr_op(3'd0, 2'b11, 16'h1234); chk_en("R9 full write");
    wr_op(3'd0, 2'b01, 16'hFFCD); chk_en("R9 low lane");
    wr_op(3'd0, 2'b10, 16'hAB00); chk_en("R9 high lane");
    wr_op(3'd1, 2'b11, 16'h0F0F); chk_en("R9 odd byte address");
    chk("R9 value", model, 16'h0F0F);

    for (int p = 0; p < 16; p++) begin
      wr_op(3'd0, 2'b11, 16'h1 << p | 16'h8001);
      for (int r = 0; r < 16; r++) begin
        raw = 16'hFFFF >> r ^ 16'(p * 16'h0911);
        #0.5;
        chk("R10 gating", gated, raw & model);
      end
    end

    wr_op(3'd0, 2'b11, 16'hC3C3);
    wr_op(3'd2, 2'b00, 16'h4040); chk_en("R11 no lanes");
    wr_op(3'd4, 2'b11, 16'h0000); chk_en("R11 address 4");
    wr_op(3'd6, 2'b11, 16'h4040); chk_en("R11 address 6");
    @(negedge clk); wdata = 16'h4000; addr = 3'd3; be = 2'b10;
    @(negedge clk); be = '0; wdata = '0;
    chk_en("R11 no strobe");
    chk("R11 value", model, 16'hC3C3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule